// File: doc/BRIEF.md
# Serial Flash Read Responder

This block plays the device side of a four-wire serial configuration memory. It answers two read commands. The fast read takes an opcode, a 24-bit address, one dummy byte, and then streams data bytes for as long as the host keeps clocking. The identity read takes an opcode and three dummy bytes, and then returns an 8-bit identifier over and over. A small array inside the block holds the data bytes. The identifier is a parameter.

The serial pins are sampled with a system clock. Chip select, serial clock and data-in first pass through a synchronizer, and the serial clock edges are found by comparing successive samples. The block takes input bits when it sees a rising serial clock edge. It changes its output bit after it sees a falling edge. The output driver is modelled as a data bit plus an enable, so the enable low means high impedance. The `busy_i` input stands in for an erase or write cycle that is in progress. While that cycle runs, identity commands are refused.

The array is `2**ADDR_W` bytes. Address bits at or above `ADDR_W` are ignored, so a smaller density parameter turns more upper bits into don't-care bits.

Top module: `srf_read_responder`

## Requirements
- R1: While `rst_ni` is low, and within a few system clocks after `cs_ni` goes high, `sdo_oe_o` is 0.
- R2: The fast read opcode is 8'h0B. The host then sends a 24-bit address MSB first, then one dummy byte, with every bit sampled on a rising serial clock edge. The byte stored at the address is then driven MSB first. Each bit is updated after a falling edge, so the first data bit is on the pin before the 41st rising edge. The array byte at address a is (a*37 + 90) mod 256.
- R3: While the clocks continue, a fast read returns bytes from successive addresses. After address `2**ADDR_W - 1` it wraps to 0.
- R4: Address bits at positions `ADDR_W` and above have no effect on the bytes returned.
- R5: The identity opcode is 8'hAB, sent MSB first. After three dummy bytes, `ID_CODE` is driven MSB first, with the first bit present before the 33rd rising edge.
- R6: While chip select stays low and the clocks continue, `ID_CODE` is sent again byte after byte.
- R7: If `busy_i` is high when an identity opcode completes, the command is ignored and `sdo_oe_o` stays 0 until chip select rises.
- R8: `sdo_oe_o` stays 0 through every opcode, address and dummy bit.
- R9: After an opcode other than 8'h0B or 8'hAB, `sdo_oe_o` stays 0 until chip select rises.
- R10: Raising chip select at any point aborts the command. The next command is decoded starting from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| busy_i | input | 1 | Erase or write cycle in progress |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |

## Verification
Fast reads are run at three addresses:
- a low address, which checks the header length and byte order;
- an address just below the top of the array, which shows whether the pointer wraps or runs past the end;
- an address with high bits set, which shows whether out-of-range bits leak into the array index.

Identity reads are run with `busy_i` low, to check the dummy count and the repetition. They are then run with `busy_i` high, which tells refusal apart from a normal reply. An unknown opcode checks that the output stays off. Commands cut short during the address phase and during the output phase show whether a later command starts from a clean state.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [2:0] {S_OP, S_ADDR, S_DUMMY, S_OUT, S_HALT} srf_state_e;

  localparam logic [7:0] OPC_FAST = 8'h0B;
  localparam logic [7:0] OPC_ID   = 8'hAB;
  localparam int OP_BITS    = 8;
  localparam int ADR_BITS   = 24;
  localparam int FAST_DUMMY = 8;
  localparam int ID_DUMMY   = 24;

  function automatic logic [7:0] fill_byte(input int unsigned a);
    int unsigned v;
    v = (a * 37 + 90) % 256;
    return v[7:0];
  endfunction
endpackage

// File: rtl/srf_sync.sv
module srf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_s_o,
  output logic sdi_s_o,
  output logic rise_o,
  output logic fall_o
);
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [STAGES-1:0][2:0] stg;
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg   <= {STAGES{RST_VAL}};
      sck_q <= 1'b0;
    end else begin
      stg   <= {stg[STAGES-2:0], {cs_ni, sck_i, sdi_i}};
      sck_q <= stg[STAGES-1][1];
    end
  end

  assign cs_s_o  = stg[STAGES-1][2];
  assign sdi_s_o = stg[STAGES-1][0];
  assign rise_o  = stg[STAGES-1][1] & ~sck_q;
  assign fall_o  = ~stg[STAGES-1][1] & sck_q;
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              rise_i,
  input  logic              sdi_s_i,
  input  logic              busy_i,
  input  logic              load_i,
  output srf_state_e        state_o,
  output logic              id_mode_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int SH_W = (ADDR_W > OP_BITS) ? ADDR_W - 1 : OP_BITS - 1;

  srf_state_e        state;
  logic [4:0]        cnt;
  logic [SH_W-1:0]   sh;
  logic [SH_W:0]     nxt;
  logic              id_mode;
  logic [ADDR_W-1:0] rd_addr;

  assign nxt = {sh, sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_OP;
      cnt     <= '0;
      sh      <= '0;
      id_mode <= 1'b0;
      rd_addr <= '0;
    end else if (cs_s_i) begin
      state   <= S_OP;
      cnt     <= '0;
      id_mode <= 1'b0;
    end else begin
      if (rise_i) begin
        sh <= nxt[SH_W-1:0];
        unique case (state)
          S_OP: begin
            if (cnt == 5'(OP_BITS - 1)) begin
              cnt <= '0;
              if (nxt[7:0] == OPC_FAST) state <= S_ADDR;
              else if (nxt[7:0] == OPC_ID && !busy_i) begin
                id_mode <= 1'b1;
                state   <= S_DUMMY;
              end else state <= S_HALT;
            end else cnt <= cnt + 5'd1;
          end
          S_ADDR: begin
            if (cnt == 5'(ADR_BITS - 1)) begin
              cnt     <= '0;
              rd_addr <= nxt[ADDR_W-1:0];  // upper bits fall out: don't-care
              state   <= S_DUMMY;
            end else cnt <= cnt + 5'd1;
          end
          S_DUMMY: begin
            if (cnt == (id_mode ? 5'(ID_DUMMY - 1) : 5'(FAST_DUMMY - 1))) begin
              cnt   <= '0;
              state <= S_OUT;
            end else cnt <= cnt + 5'd1;
          end
          default: ;
        endcase
      end
      if (load_i && !id_mode) rd_addr <= rd_addr + 1'b1;
    end
  end

  assign state_o   = state;
  assign id_mode_o = id_mode;
  assign rd_addr_o = rd_addr;
endmodule

// File: rtl/srf_mem.sv
module srf_mem
  import srf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_byte(i);
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/srf_tx.sv
module srf_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_s_i,
  input  logic       fall_i,
  input  logic       active_i,
  input  logic [7:0] byte_i,
  output logic       load_o,
  output logic       sdo_o,
  output logic       oe_o
);
  logic [7:0] sh;
  logic [2:0] pos;
  logic       oe;

  assign load_o = fall_i & active_i & ~cs_s_i & (~oe | (pos == 3'd7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh  <= '0;
      pos <= '0;
      oe  <= 1'b0;
    end else if (cs_s_i) begin
      pos <= '0;
      oe  <= 1'b0;
    end else if (fall_i && active_i) begin
      if (load_o) begin
        sh  <= byte_i;
        pos <= '0;
        oe  <= 1'b1;
      end else begin
        sh  <= {sh[6:0], 1'b0};
        pos <= pos + 3'd1;
      end
    end
  end

  assign sdo_o = sh[7];
  assign oe_o  = oe;
endmodule

// File: rtl/srf_read_responder.sv
module srf_read_responder
  import srf_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] ID_CODE = 8'h10,
  parameter int         SYNC_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic busy_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              cs_s, sdi_s, sck_rise, sck_fall;
  logic              id_mode, load;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        mem_data, tx_byte;
  srf_state_e        state;

  srf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i,
    .cs_s_o(cs_s), .sdi_s_o(sdi_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  srf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .cs_s_i(cs_s), .rise_i(sck_rise), .sdi_s_i(sdi_s),
    .busy_i, .load_i(load), .state_o(state), .id_mode_o(id_mode),
    .rd_addr_o(rd_addr)
  );

  srf_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_data_o(mem_data)
  );

  assign tx_byte = id_mode ? ID_CODE : mem_data;

  srf_tx u_tx (
    .clk_i, .rst_ni, .cs_s_i(cs_s), .fall_i(sck_fall),
    .active_i(state == S_OUT), .byte_i(tx_byte), .load_o(load),
    .sdo_o, .oe_o(sdo_oe_o)
  );
endmodule

// File: rtl/srf_checker.sv
module srf_checker
  import srf_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       sck_fall,
  input srf_state_e state,
  input logic       sdo_o,
  input logic       sdo_oe_o
);
  // R1
  release_on_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_oe_o);

  // R8
  quiet_header_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_OUT) |-> !sdo_oe_o);

  // R9
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_HALT && !cs_s) |=> (state == S_HALT));

  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (state == S_OP));

  // R2
  fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall |=> $stable(sdo_o));
endmodule

bind srf_read_responder srf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .sck_fall(sck_fall),
  .state(state), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/sim_srf_read_responder.sv
module sim_srf_read_responder;
  localparam int         ADDR_W = 8;
  localparam logic [7:0] ID     = 8'h10;
  localparam int         HP     = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srf_read_responder #(.ADDR_W(ADDR_W), .ID_CODE(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .busy_i(busy), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  function automatic logic [7:0] pat(input int unsigned a);
    int unsigned v;
    v = ((a % (2 ** ADDR_W)) * 37 + 90) % 256;
    return v[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic so, output logic en);
    @(negedge clk);
    sck = 1'b0;
    sdi = b;
    repeat (HP) @(negedge clk);
    so  = sdo;
    en  = sdo_oe;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, inout int oe_cnt);
    logic so, en;
    for (int i = 7; i >= 0; i--) begin
      bit_io(v[i], so, en);
      oe_cnt += int'(en);
    end
  endtask

  task automatic recv_byte(output logic [7:0] v, output int oe_cnt);
    logic so, en;
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b0, so, en);
      v[i] = so;
      oe_cnt += int'(en);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end(input string req);
    @(negedge clk);
    sck = 1'b0;
    repeat (HP) @(negedge clk);
    cs_ni = 1'b1;
    repeat (HP) @(negedge clk);
    check(sdo_oe == 1'b0, req, "output released after cs high", int'(sdo_oe), 0);
  endtask

  task automatic t_reset();
    check(sdo_oe == 1'b0, "R1", "enable in reset", int'(sdo_oe), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(sdo_oe == 1'b0, "R1", "enable idle after reset", int'(sdo_oe), 0);
  endtask

  task automatic t_fast(input logic [23:0] addr, input int n, input string req);
    int hdr = 0, oec;
    logic [7:0] v;
    cs_begin();
    send_byte(8'h0B, hdr);
    send_byte(addr[23:16], hdr);
    send_byte(addr[15:8], hdr);
    send_byte(addr[7:0], hdr);
    send_byte(8'h00, hdr);
    check(hdr == 0, "R8", "enable during fast header", hdr, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(v, oec);
      check(v == pat(int'(addr) + i), req, "fast read byte", int'(v),
            int'(pat(int'(addr) + i)));
      check(oec == 8, "R2", "enable during data", oec, 8);
    end
    cs_end("R1");
  endtask

  task automatic t_id(input logic bsy, input int n);
    int hdr = 0, oec;
    logic [7:0] v;
    busy = bsy;
    cs_begin();
    send_byte(8'hAB, hdr);
    busy = 1'b0;
    send_byte(8'h00, hdr);
    send_byte(8'h00, hdr);
    send_byte(8'h00, hdr);
    check(hdr == 0, "R8", "enable during id header", hdr, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(v, oec);
      if (bsy) check(oec == 0, "R7", "enable while busy id", oec, 0);
      else begin
        check(v == ID, (i == 0) ? "R5" : "R6", "id byte", int'(v), int'(ID));
        check(oec == 8, "R5", "enable during id", oec, 8);
      end
    end
    cs_end("R1");
  endtask

  task automatic t_unknown();
    int hdr = 0, oec;
    logic [7:0] v;
    cs_begin();
    send_byte(8'h9F, hdr);
    for (int i = 0; i < 5; i++) begin
      recv_byte(v, oec);
      hdr += oec;
    end
    check(hdr == 0, "R9", "enable after unknown opcode", hdr, 0);
    cs_end("R9");
  endtask

  task automatic t_abort();
    int hdr = 0, oec;
    logic so, en;
    logic [7:0] v;
    cs_begin();
    send_byte(8'h0B, hdr);
    send_byte(8'h55, hdr);
    bit_io(1'b1, so, en);
    cs_end("R10");
    t_fast(24'h000003, 1, "R10");
    cs_begin();
    send_byte(8'hAB, hdr);
    repeat (3) send_byte(8'h00, hdr);
    recv_byte(v, oec);
    bit_io(1'b0, so, en);
    bit_io(1'b0, so, en);
    cs_end("R10");
    t_fast(24'h000040, 2, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fast(24'h000010, 3, "R2");
    t_fast(24'h0000FE, 4, "R3");
    t_fast(24'hABCD12, 2, "R4");
    t_id(1'b0, 3);
    t_id(1'b1, 3);
    t_id(1'b0, 1);
    t_unknown();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule